// File: doc/BRIEF.md
# Filtered LFSR Keystream Generator

This block is a bit-serial stream cipher core. A 48-bit shift register feeds a two-level nonlinear filter. The first level is five 4-input lookup subfunctions. The second level is a 5-input lookup combiner that produces a single bit. A start pulse seeds the register from a 32-bit serial number and the upper 16 bits of a 48-bit key. The core then spends 32 cycles mixing the lower 32 key bits and a 32-bit IV into the register.

After that the core produces one keystream bit per cycle, for as long as it is left running. Each bit is shifted into a 32-bit word. A one-cycle done flag marks each cycle in which the word holds 32 fresh bits. The host drives key, serial and IV, pulses start, and reads either the serial bit stream or the packed words. A new start at any time abandons the current stream and begins again.

Top module: `lfsr_keystream_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the following cycle shows ks_valid = 0, done = 0 and ks_word = 0.
- R2: A start sampled at a clock edge loads the register with serial in bits 47:16 and key[47:32] in bits 15:0. The register shifts toward bit 47 every cycle and takes each new bit into bit 0.
- R3: The filter uses two 4-input lookup functions, A = bit i of 0x2C79 and B = bit i of 0x6671. It applies them to the register bit groups A(45,44,42,41), B(39,35,33,32), B(30,26,24,21), B(19,18,16,14) and A(13,4,3,1). In each group the first listed bit is the index LSB. The five results form a combiner index, with the first group as the LSB, and the filter output is bit i of 0x7907287B.
- R4: The 32 cycles that follow the start edge are initialisation cycles. On initialisation cycle r (0 to 31), the bit taken in is filter XOR key[31−r] XOR iv[31−r]. ks_valid stays low throughout these cycles and rises after the 32nd clock edge that follows the start edge.
- R5: While ks_valid is high, ks_bit equals the filter output. The bit taken in is the XOR of register bits 47, 45, 44, 41, 40, 39, 31, 25, 24, 21, 17, 6, 5, 4, 1 and 0.
- R6: Every valid keystream bit is shifted left into ks_word at bit 0. After 32 bits, the first keystream bit sits in bit 31.
- R7: done is high for exactly one cycle, the cycle in which ks_word first holds each complete group of 32 keystream bits. Keystream generation continues afterwards, and done pulses again after every further 32 bits.
- R8: A start sampled during initialisation or keystream output restarts the sequence. In the following cycle ks_valid = 0, done = 0 and ks_word = 0, and the keystream produced afterwards depends only on the new inputs.
- R9: Once ks_valid is high, it stays high until the next start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin load and initialisation |
| key | input | 48 | Secret key |
| serial | input | 32 | Serial number seeded into the register |
| iv | input | 32 | Initialisation vector mixed in during setup |
| ks_bit | output | 1 | Keystream bit, meaningful while ks_valid is high |
| ks_valid | output | 1 | High while keystream bits are produced |
| ks_word | output | WORD_W (32) | Keystream bits packed MSB-first |
| done | output | 1 | One-cycle pulse when a full word is packed |

## Verification
The hardest condition to reach from the ports is a start that arrives in the middle of a stream. The restart must leave no trace of the old key in the register, the mixing shift registers or the word packer. The stimulus therefore abandons runs part-way through initialisation and part-way through keystream output. It then compares the full 64-bit stream that follows against a fresh model run on the new inputs alone. An all-zero input exercises the fixed point where the filter returns 0 and the stream stays zero. Random key, serial and IV sets exercise every table entry with high probability.

// File: rtl/ksg_pkg.sv
// Package: shared sizes, lookup constants and tap positions for the
// filtered LFSR keystream generator. Assumes a 48-bit state and a
// 32-cycle initialisation driven by 32 key bits and 32 IV bits.
package ksg_pkg;
    localparam int KEY_W  = 48;
    localparam int ID_W   = 32;
    localparam int IV_W   = 32;
    localparam int ST_W   = 48;
    localparam int INIT_N = 32;
    localparam int SEED_K = ST_W - ID_W;   // key bits placed at load
    localparam int N_GRP  = 5;
    localparam int GRP_IN = 4;

    localparam logic [15:0] LUT_A   = 16'h2C79;
    localparam logic [15:0] LUT_B   = 16'h6671;
    localparam logic [31:0] LUT_MIX = 32'h7907287B;
    // Linear feedback tap mask used during keystream output
    localparam logic [ST_W-1:0] FB_MASK = 48'hB380_8322_0073;
    // Which groups use table A (1) versus table B (0)
    localparam logic [N_GRP-1:0] GRP_IS_A = 5'b10001;

    typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_RUN} phase_t;

    // Register bit feeding input k (k = 0 is LSB) of group g
    function automatic int tap_pos(input int g, input int k);
        int p;
        case (g)
            0: case (k) 0: p = 45; 1: p = 44; 2: p = 42; default: p = 41; endcase
            1: case (k) 0: p = 39; 1: p = 35; 2: p = 33; default: p = 32; endcase
            2: case (k) 0: p = 30; 1: p = 26; 2: p = 24; default: p = 21; endcase
            3: case (k) 0: p = 19; 1: p = 18; 2: p = 16; default: p = 14; endcase
            default: case (k) 0: p = 13; 1: p = 4; 2: p = 3; default: p = 1; endcase
        endcase
        return p;
    endfunction
endpackage

// File: rtl/ksg_filter.sv
// Module: ksg_filter
// Two-level nonlinear filter. Five 4-input lookups on fixed register
// taps feed one 5-input lookup. Purely combinational; assumes ST_W = 48.
module ksg_filter
    import ksg_pkg::*;
(
    input  logic [ST_W-1:0] state,
    output logic            f_out
);
    logic [N_GRP-1:0] grp_out;

    // Build each first-level lookup from its four taps
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [GRP_IN-1:0] idx;
        for (genvar k = 0; k < GRP_IN; k++) begin : g_tap
            localparam int P = tap_pos(g, k);
            assign idx[k] = state[P];
        end
        if (GRP_IS_A[g]) begin : g_a
            assign grp_out[g] = LUT_A[idx];
        end else begin : g_b
            assign grp_out[g] = LUT_B[idx];
        end
    end

    // Second-level combiner lookup
    always_comb f_out = LUT_MIX[grp_out];
endmodule

// File: rtl/ksg_ctrl.sv
// Module: ksg_ctrl
// Phase sequencer: idle, then INIT_CYC initialisation cycles, then
// keystream output until the next start. A start always wins.
module ksg_ctrl
    import ksg_pkg::*;
#(
    parameter int INIT_CYC = INIT_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic in_init,
    output logic in_run
);
    localparam int CW = $clog2(INIT_CYC);

    phase_t        phase;
    logic [CW-1:0] cyc;

    // Advance the phase and count initialisation cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cyc   <= '0;
        end else if (start) begin
            phase <= PH_INIT;
            cyc   <= '0;
        end else if (phase == PH_INIT) begin
            if (cyc == CW'(INIT_CYC - 1)) begin
                phase <= PH_RUN;
                cyc   <= '0;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // Decode phase flags
    always_comb begin
        in_init = (phase == PH_INIT);
        in_run  = (phase == PH_RUN);
    end
endmodule

// File: rtl/ksg_pack.sv
// Module: ksg_pack
// Packs valid keystream bits MSB-first into a word and raises a
// one-cycle flag when each full word is present. Cleared by start.
module ksg_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic              full
);
    localparam int NW = $clog2(WORD_W);

    logic [NW-1:0] fill;

    // Shift in bits and flag every WORD_W-th capture
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
            fill <= '0;
            full <= 1'b0;
        end else begin
            full <= 1'b0;
            if (bit_vld) begin
                word <= {word[WORD_W-2:0], bit_in};
                if (fill == NW'(WORD_W - 1)) begin
                    fill <= '0;
                    full <= 1'b1;
                end else begin
                    fill <= fill + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lfsr_keystream_gen.sv
// Module: lfsr_keystream_gen (top)
// Bit-serial filtered-LFSR keystream generator. Start loads the state
// from serial and upper key bits, 32 cycles mix in key[31:0] and iv
// MSB-first, then one keystream bit per cycle is emitted and packed.
// Assumes key, serial and iv are stable only in the start cycle.
module lfsr_keystream_gen
    import ksg_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KEY_W-1:0]  key,
    input  logic [ID_W-1:0]   serial,
    input  logic [IV_W-1:0]   iv,
    output logic              ks_bit,
    output logic              ks_valid,
    output logic [WORD_W-1:0] ks_word,
    output logic              done
);
    localparam int MIX_W = KEY_W - SEED_K;

    logic [ST_W-1:0]  st;
    logic [MIX_W-1:0] key_sh;
    logic [IV_W-1:0]  iv_sh;
    logic             filt;
    logic             in_init;
    logic             in_run;
    logic             lin_fb;

    ksg_filter u_filter (.state(st), .f_out(filt));

    ksg_ctrl #(.INIT_CYC(INIT_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_init(in_init), .in_run(in_run)
    );

    // Linear feedback for the keystream phase
    always_comb lin_fb = ^(st & FB_MASK);

    // State register: load, keyed initialisation, or linear stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (start) begin
            st <= {serial, key[KEY_W-1:MIX_W]};
        end else if (in_init) begin
            st <= {st[ST_W-2:0], filt ^ key_sh[MIX_W-1] ^ iv_sh[IV_W-1]};
        end else if (in_run) begin
            st <= {st[ST_W-2:0], lin_fb};
        end
    end

    // Capture and step the mixing key and IV bits, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_sh <= '0;
            iv_sh  <= '0;
        end else if (start) begin
            key_sh <= key[MIX_W-1:0];
            iv_sh  <= iv;
        end else if (in_init) begin
            key_sh <= {key_sh[MIX_W-2:0], 1'b0};
            iv_sh  <= {iv_sh[IV_W-2:0], 1'b0};
        end
    end

    // Keystream outputs
    always_comb begin
        ks_valid = in_run;
        ks_bit   = filt & in_run;
    end

    ksg_pack #(.WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .bit_vld(in_run), .bit_in(filt),
        .word(ks_word), .full(done)
    );
endmodule

// File: rtl/ksg_checker.sv
// Module: ksg_checker
// Assertion checker bound to lfsr_keystream_gen. Tracks cycles since
// the last start with its own counter to check the initialisation window.
module ksg_checker #(
    parameter int INIT_CYC = 32,
    parameter int WORD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ks_bit,
    input logic              ks_valid,
    input logic [WORD_W-1:0] ks_word,
    input logic              done
);
    localparam int CW = $clog2(INIT_CYC + 1);

    logic          armed;
    logic [CW-1:0] since;

    // Count cycles since the last start, saturating at INIT_CYC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            since <= '0;
        end else if (start) begin
            armed <= 1'b1;
            since <= '0;
        end else if (armed && since != CW'(INIT_CYC)) begin
            since <= since + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!ks_valid && !done && ks_word == '0));

    // R4
    init_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid == (armed && since == CW'(INIT_CYC)));

    // R6
    word_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !start) |=>
            (ks_word[0] == $past(ks_bit) && ks_word[WORD_W-1:1] == $past(ks_word[WORD_W-2:0])));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ks_valid));

    // R8
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ks_valid && !done && ks_word == '0));

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !start) |=> ks_valid);
endmodule

bind lfsr_keystream_gen ksg_checker #(.INIT_CYC(ksg_pkg::INIT_N), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ks_bit(ks_bit),
    .ks_valid(ks_valid), .ks_word(ks_word), .done(done)
);

// File: tb/lfsr_keystream_gen_bench.sv
module lfsr_keystream_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] key = '0;
    logic [31:0] serial = '0;
    logic [31:0] iv = '0;
    logic        ks_bit;
    logic        ks_valid;
    logic [31:0] ks_word;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    lfsr_keystream_gen u_lfsr_keystream_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .serial(serial),
        .iv(iv), .ks_bit(ks_bit), .ks_valid(ks_valid), .ks_word(ks_word), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    // R3 model: nonlinear filter, written from the requirement text
    function automatic logic ref_filter(input logic [47:0] s);
        logic [4:0] c;
        c[0] = 1'((16'h2C79 >> {s[41], s[42], s[44], s[45]}) & 16'h1);
        c[1] = 1'((16'h6671 >> {s[32], s[33], s[35], s[39]}) & 16'h1);
        c[2] = 1'((16'h6671 >> {s[21], s[24], s[26], s[30]}) & 16'h1);
        c[3] = 1'((16'h6671 >> {s[14], s[16], s[18], s[19]}) & 16'h1);
        c[4] = 1'((16'h2C79 >> {s[1], s[3], s[4], s[13]}) & 16'h1);
        return 1'((32'h7907287B >> c) & 32'h1);
    endfunction

    // R2/R4/R5 model: 64 keystream bits, first bit in bit 63
    function automatic logic [63:0] ref_stream(input logic [47:0] k, input logic [31:0] s, input logic [31:0] v);
        logic [47:0] st;
        logic [63:0] out;
        logic        nb;
        st = {s, k[47:32]};
        for (int r = 0; r < 32; r++) begin
            nb = ref_filter(st) ^ k[31 - r] ^ v[31 - r];
            st = {st[46:0], nb};
        end
        for (int j = 0; j < 64; j++) begin
            out[63 - j] = ref_filter(st);
            nb = st[47] ^ st[45] ^ st[44] ^ st[41] ^ st[40] ^ st[39] ^ st[31] ^ st[25]
               ^ st[24] ^ st[21] ^ st[17] ^ st[6] ^ st[5] ^ st[4] ^ st[1] ^ st[0];
            st = {st[46:0], nb};
        end
        return out;
    endfunction

    // Pulse start with the given inputs; check the restart state (R8)
    task automatic pulse_start(input logic [47:0] k, input logic [31:0] s, input logic [31:0] v);
        @(negedge clk);
        key = k; serial = s; iv = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0; key = '0; serial = '0; iv = '0;
        check(!ks_valid && !done && ks_word == '0, "R8 restart clear",
              {ks_valid, done, ks_word}, 64'd0);
    endtask

    // Run a full stream after a start that has just been pulsed
    task automatic run_stream(input logic [47:0] k, input logic [31:0] s, input logic [31:0] v, input string tag);
        logic [63:0] exp_s;
        bit init_ok = 1, bits_ok = 1, done_ok = 1;
        logic [63:0] got;
        exp_s = ref_stream(k, s, v);
        got = '0;
        // the negedge after the start edge is c = 0
        for (int c = 1; c <= 96; c++) begin
            @(negedge clk);
            if (c < 32 && ks_valid) init_ok = 0;
            if (c >= 32 && !ks_valid) bits_ok = 0;
            if (c >= 32 && c < 96) begin
                got[63 - (c - 32)] = ks_bit;
                if (ks_bit !== exp_s[63 - (c - 32)]) bits_ok = 0;
            end
            if (c == 64) check(done && ks_word == exp_s[63:32], {"R6 R7 first word ", tag},
                               {31'd0, done, ks_word}, {32'd1, exp_s[63:32]});
            else if (c == 96) check(done && ks_word == exp_s[31:0], {"R7 second word ", tag},
                               {31'd0, done, ks_word}, {32'd1, exp_s[31:0]});
            else if (done) done_ok = 0;
        end
        check(init_ok, {"R4 valid low in init ", tag}, 64'(init_ok), 64'd1);
        check(bits_ok, {"R2 R3 R5 R9 keystream ", tag}, got, exp_s);
        check(done_ok, {"R7 done single pulse ", tag}, 64'(done_ok), 64'd1);
    endtask

    initial begin
        logic [47:0] k;
        logic [31:0] s, v;
        void'($urandom(32'd7719));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!ks_valid && !done && ks_word == '0, "R1 reset state", {ks_valid, done, ks_word}, 64'd0);
        rst_n = 1'b1;

        // Directed: all zero inputs give an all-zero stream
        pulse_start('0, '0, '0);
        run_stream('0, '0, '0, "zeros");

        // Directed: all ones
        pulse_start('1, '1, '1);
        run_stream('1, '1, '1, "ones");

        // Directed: single key bit feeding the first init cycle
        pulse_start(48'h0000_8000_0000, 32'h0, 32'h0);
        run_stream(48'h0000_8000_0000, 32'h0, 32'h0, "keybit31");

        // R8: restart in the middle of initialisation
        pulse_start(48'hA5A5_0F0F_1234, 32'hDEAD_BEEF, 32'h1357_9BDF);
        repeat (17) @(negedge clk);
        k = {$urandom, $urandom}; s = $urandom; v = $urandom;
        pulse_start(k, s, v);
        run_stream(k, s, v, "restart in init");

        // R8: restart in the middle of keystream output
        repeat (23) @(negedge clk);
        k = {$urandom, $urandom}; s = $urandom; v = $urandom;
        pulse_start(k, s, v);
        run_stream(k, s, v, "restart in run");

        // Random sets
        for (int n = 0; n < 12; n++) begin
            k = {$urandom, $urandom}; s = $urandom; v = $urandom;
            pulse_start(k, s, v);
            run_stream(k, s, v, "random");
        end

        // R1: reset in the middle of output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!ks_valid && !done && ks_word == '0, "R1 reset mid-run", {ks_valid, done, ks_word}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(!ks_valid, "R1 stays idle after reset", 64'(ks_valid), 64'd0);

        summary();
    end
endmodule